// File: doc/BRIEF.md
# Streaming Border Pixel Replicator

This block follows a separable K-tap filter. The filter hands it a reduced stream of pixels, and the block rebuilds a full width-by-height raster from that stream by copying edge pixels out into the border. It keeps three stores: one line of cached samples, a register for the left edge and a register for the right edge. The border rows and border columns take their values from these stores and read no new input.

Each frame begins with a one-cycle start pulse, which captures the runtime width and height. After that the block steps through the raster one position per clock and has no gaps of its own. Only the consuming rows pull samples from the input stream. Every other row replays what is cached. Both sides use a valid/ready handshake. The block pulses done once the last pixel of the frame has been accepted.

Top module: `border_replicator`

## Requirements
- R1: After reset, and between frames, out_valid, in_ready and done stay low. A start pulse captures cfg_width and cfg_height and begins the raster at row 0, column 0. A later change on cfg_width or cfg_height has no effect on the running frame. Legal sizes are K <= width <= MAX_COLS and K <= height <= MAX_ROWS.
- R2: A frame produces exactly width*height accepted output pixels in raster order. done is high for exactly one cycle, the cycle after the final pixel is accepted, and the block is idle after that.
- R3: With B = K/2, the consuming rows are row 0 and the rows r where B < r < height-B. No other row asserts in_ready. Over a frame, the block accepts exactly (height-2B)*(width-K+1) input samples.
- R4: On a consuming row, input is requested only at columns c < width-(K-1). The sample taken at column c is written to cache slot c.
- R5: The sample taken at column 0 of a consuming row becomes the left-edge pixel. The sample taken at column width-K becomes the right-edge pixel. At column 0 the pixel just taken is output in the same cycle.
- R6: The output at column c is chosen in this order. It is the left-edge pixel if c <= B. Otherwise it is the right-edge pixel if c >= width-B-1. Otherwise it is cache slot c-B.
- R7: When input is always valid and output is always ready, a frame takes exactly width*height cycles from start to its last accept.
- R8: A position that needs input while in_valid is low holds out_valid low. While out_ready is low, in_ready is low. During either stall no state moves, and a held output keeps its value.
- R9: Rows 1..B repeat row 0. Rows height-B..height-1 repeat the last consuming row. The cache and both edge registers keep their contents across rows until they are overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start pulse; captures the size |
| cfg_width | input | $clog2(MAX_COLS+1) | Frame width in pixels |
| cfg_height | input | $clog2(MAX_ROWS+1) | Frame height in rows |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DATA_W | Filtered input sample |
| in_ready | output | 1 | Block takes the sample this cycle |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | DATA_W | Output pixel |
| out_ready | input | 1 | Sink accepts the pixel |
| done | output | 1 | One-cycle pulse after the frame's last accept |

## Verification
The bench sweeps many frame shapes. These include the smallest legal width and height, where the two edge regions meet and no middle consuming row exists. In those shapes a wrong replay-row choice would repeat row 0 where the last consuming row belongs, or the reverse. Each mode of input and output stalls is exercised, so the bench catches a design that advances or reads a sample while the other side is stalled. Every cycle the bench predicts in_ready and out_valid from the position and compares them with the design. The comparison exposes any design that requests input on a replay row or at a column past width-K. The bench also catches a column-0 output that shows the old left edge in place of the sample just taken.

// File: rtl/brd_pkg.sv
package brd_pkg;

  typedef enum logic [1:0] {
    SRC_LEFT  = 2'd0,
    SRC_CACHE = 2'd1,
    SRC_RIGHT = 2'd2
  } px_src_e;

  // Row takes fresh input: the first row, or rows clear of both border bands.
  function automatic logic row_consumes(int unsigned row, int unsigned height,
                                        int unsigned bw);
    return (row == 0) || ((row > bw) && (row < height - bw));
  endfunction

  // Column reads a sample: the shrunken line has width-(k-1) entries.
  function automatic logic col_reads(int unsigned col, int unsigned width,
                                     int unsigned k);
    return col < width - (k - 1);
  endfunction

  // Output source for a column; the left band wins on overlap.
  function automatic px_src_e col_source(int unsigned col, int unsigned width,
                                         int unsigned bw);
    if (col <= bw)                 return SRC_LEFT;
    else if (col >= width - bw - 1) return SRC_RIGHT;
    else                           return SRC_CACHE;
  endfunction

endpackage

// File: rtl/brd_scan_ctrl.sv
module brd_scan_ctrl #(
  parameter int CW = 7,
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cfg_width,
  input  logic [RW-1:0] cfg_height,
  input  logic          step,
  output logic          active,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic [CW-1:0] wid,
  output logic [RW-1:0] hgt,
  output logic          last,
  output logic          done
);

  logic row_end;

  assign row_end = (col == wid - CW'(1));
  assign last    = row_end && (row == hgt - RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      col    <= '0;
      row    <= '0;
      wid    <= '0;
      hgt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        col    <= '0;
        row    <= '0;
        wid    <= cfg_width;
        hgt    <= cfg_height;
      end else if (step) begin
        if (row_end) begin
          col <= '0;
          if (last) begin
            active <= 1'b0;
            row    <= '0;
            done   <= 1'b1;
          end else begin
            row <= row + RW'(1);
          end
        end else begin
          col <= col + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/brd_line_cache.sv
module brd_line_cache #(
  parameter int DATA_W  = 8,
  parameter int CACHE_D = 62,
  parameter int CW      = 7,
  parameter int BW      = 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              byp_en,
  input  logic [CW-1:0]     col,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int IW = (CACHE_D > 1) ? $clog2(CACHE_D) : 1;

  logic [DATA_W-1:0] mem [CACHE_D];
  logic [CW-1:0]     rd_col;
  logic [DATA_W-1:0] stored;

  assign rd_col = col - CW'(BW);

  always_ff @(posedge clk) begin
    if (wr_en && (32'(col) < 32'(CACHE_D)))
      mem[col[IW-1:0]] <= wr_data;
  end

  assign stored  = (32'(rd_col) < 32'(CACHE_D)) ? mem[rd_col[IW-1:0]] : '0;
  // Only with a zero-wide border can the read slot equal the slot being filled.
  assign rd_data = (byp_en && (rd_col == col)) ? wr_data : stored;

endmodule

// File: rtl/brd_edge_regs.sv
module brd_edge_regs #(
  parameter int DATA_W = 8,
  parameter int CW     = 7,
  parameter int K      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              need_in,
  input  logic [CW-1:0]     col,
  input  logic [CW-1:0]     wid,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] left_px,
  output logic [DATA_W-1:0] right_px
);

  logic [DATA_W-1:0] left_q, right_q;
  logic [CW-1:0]     right_col;
  logic              at_left, at_right;

  assign right_col = wid - CW'(K);
  assign at_left   = (col == '0);
  assign at_right  = (col == right_col);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
    end else begin
      if (take && at_left)  left_q  <= in_data;
      if (take && at_right) right_q <= in_data;
    end
  end

  assign left_px  = (need_in && at_left)  ? in_data : left_q;
  assign right_px = (need_in && at_right) ? in_data : right_q;

endmodule

// File: rtl/brd_pix_select.sv
module brd_pix_select
  import brd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  px_src_e           sel,
  input  logic [DATA_W-1:0] left_px,
  input  logic [DATA_W-1:0] right_px,
  input  logic [DATA_W-1:0] cache_px,
  output logic [DATA_W-1:0] pix
);

  always_comb begin
    unique case (sel)
      SRC_LEFT:  pix = left_px;
      SRC_RIGHT: pix = right_px;
      SRC_CACHE: pix = cache_px;
      default:   pix = '0;
    endcase
  end

endmodule

// File: rtl/border_replicator.sv
module border_replicator
  import brd_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MAX_COLS = 64,
  parameter int MAX_ROWS = 64,
  parameter int K        = 3,
  localparam int CW      = $clog2(MAX_COLS + 1),
  localparam int RW      = $clog2(MAX_ROWS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     cfg_width,
  input  logic [RW-1:0]     cfg_height,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              done
);

  localparam int BW      = K / 2;
  localparam int CACHE_D = MAX_COLS - (K - 1);

  logic          active, last;
  logic [CW-1:0] col, wid;
  logic [RW-1:0] row, hgt;
  logic          row_cons, col_read, need_in, fire, take;
  px_src_e       sel;
  logic [DATA_W-1:0] left_px, right_px, cache_px;

  assign row_cons  = row_consumes(32'(row), 32'(hgt), BW);
  assign col_read  = col_reads(32'(col), 32'(wid), K);
  assign need_in   = row_cons && col_read;
  assign sel       = col_source(32'(col), 32'(wid), BW);

  assign out_valid = active && (!need_in || in_valid);
  assign in_ready  = active && need_in && out_ready;
  assign fire      = out_valid && out_ready;
  assign take      = fire && need_in;

  brd_scan_ctrl #(.CW(CW), .RW(RW)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_width  (cfg_width),
    .cfg_height (cfg_height),
    .step       (fire),
    .active     (active),
    .col        (col),
    .row        (row),
    .wid        (wid),
    .hgt        (hgt),
    .last       (last),
    .done       (done)
  );

  brd_line_cache #(.DATA_W(DATA_W), .CACHE_D(CACHE_D), .CW(CW), .BW(BW)) u_cache (
    .clk     (clk),
    .wr_en   (take),
    .byp_en  (need_in),
    .col     (col),
    .wr_data (in_data),
    .rd_data (cache_px)
  );

  brd_edge_regs #(.DATA_W(DATA_W), .CW(CW), .K(K)) u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .need_in  (need_in),
    .col      (col),
    .wid      (wid),
    .in_data  (in_data),
    .left_px  (left_px),
    .right_px (right_px)
  );

  brd_pix_select #(.DATA_W(DATA_W)) u_sel (
    .sel      (sel),
    .left_px  (left_px),
    .right_px (right_px),
    .cache_px (cache_px),
    .pix      (out_data)
  );

endmodule

// File: rtl/brd_checker.sv
module brd_checker #(
  parameter int CW = 7,
  parameter int RW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          active,
  input logic [CW-1:0] col,
  input logic [RW-1:0] row,
  input logic [CW-1:0] wid,
  input logic [RW-1:0] hgt,
  input logic          last,
  input logic          row_cons,
  input logic          fire,
  input logic          in_ready,
  input logic          out_valid,
  input logic          done
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!out_valid && !in_ready)); // R1

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last && !start) |=> done); // R2

  AST_DONE_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fire && last && !start)); // R2

  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(start)) |-> !active); // R2

  AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((col < wid) && (row < hgt))); // R2

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !start && (col != wid - CW'(1))) |=> (col == $past(col) + CW'(1))); // R2

  AST_NO_READ_ON_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    !row_cons |-> !in_ready); // R3

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fire && !start) |=> ($stable(col) && $stable(row))); // R8

endmodule

bind border_replicator brd_checker #(.CW(CW), .RW(RW)) u_brd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .active    (active),
  .col       (col),
  .row       (row),
  .wid       (wid),
  .hgt       (hgt),
  .last      (last),
  .row_cons  (row_cons),
  .fire      (fire),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .done      (done)
);

// File: tb/test_border_replicator.sv
module test_border_replicator;

  localparam int DW  = 8;
  localparam int MC  = 16;
  localparam int MR  = 16;
  localparam int KT  = 3;
  localparam int BWT = KT / 2;
  localparam int CWT = $clog2(MC + 1);
  localparam int RWT = $clog2(MR + 1);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [CWT-1:0] cfg_width;
  logic [RWT-1:0] cfg_height;
  logic           in_valid;
  logic [DW-1:0]  in_data;
  logic           in_ready;
  logic           out_valid;
  logic [DW-1:0]  out_data;
  logic           out_ready;
  logic           done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  border_replicator #(.DATA_W(DW), .MAX_COLS(MC), .MAX_ROWS(MR), .K(KT)) i_border_replicator (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_width  (cfg_width),
    .cfg_height (cfg_height),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .done       (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sample_val(int seed, int n);
    return (n * 37 + seed * 11 + 5) % 256;
  endfunction

  function automatic bit takes_row(int r, int h);
    return (r == 0) || (r > BWT && r < h - BWT);
  endfunction

  // Ordinal of the consuming row whose data appears on row r.
  function automatic int row_ordinal(int r, int h);
    int s;
    if (takes_row(r, h))  s = r;
    else if (r <= BWT)    s = 0;
    else                  s = (h - BWT - 1 > BWT) ? h - BWT - 1 : 0;
    return (s == 0) ? 0 : s - BWT;
  endfunction

  function automatic int line_index(int c, int w);
    if (c <= BWT)          return 0;
    if (c >= w - BWT - 1)  return w - KT;
    return c - BWT;
  endfunction

  task automatic run_frame(input int w, input int h, input int mode, input int seed);
    int k = 0, n = 0, cycles = 0;
    int nin = (h - 2 * BWT) * (w - KT + 1);
    bit held = 0, prev_stall = 0;
    logic [DW-1:0] prev_data = '0;
    @(negedge clk);
    start = 1'b1; cfg_width = CWT'(w); cfg_height = RWT'(h);
    in_valid = 1'b0; out_ready = 1'b0;
    while (k < w * h && cycles < 20000) begin
      int r, c, exp_v;
      bit need;
      @(negedge clk);
      start = 1'b0;
      // Scramble the size inputs mid-frame (R1: captured at start only).
      cfg_width = CWT'($urandom); cfg_height = RWT'($urandom);
      if (!held) begin
        in_valid = (n < nin) && (((mode & 1) == 0) || ($urandom % 3 != 0));
        in_data  = DW'(sample_val(seed, n));
      end
      out_ready = ((mode & 2) == 0) || ($urandom % 3 != 0);
      #1;
      r = k / w; c = k % w;
      need = takes_row(r, h) && (c < w - KT + 1);
      check(in_ready == (need && out_ready), "R4", "in_ready", int'(in_ready),
            int'(need && out_ready));
      check(out_valid == (!need || in_valid), "R8", "out_valid", int'(out_valid),
            int'(!need || in_valid));
      if (prev_stall)
        check(out_valid && out_data == prev_data, "R8", "held pixel",
              int'(out_data), int'(prev_data));
      if (out_valid && out_ready) begin
        exp_v = sample_val(seed, row_ordinal(r, h) * (w - KT + 1) + line_index(c, w));
        if (!takes_row(r, h))
          check(out_data == DW'(exp_v), "R9", "replayed pixel", int'(out_data), exp_v);
        else if (c <= BWT || c >= w - BWT - 1)
          check(out_data == DW'(exp_v), "R5", "edge pixel", int'(out_data), exp_v);
        else
          check(out_data == DW'(exp_v), "R6", "cached pixel", int'(out_data), exp_v);
        k++;
      end
      if (in_valid && in_ready) begin n++; held = 0; end
      else held = in_valid;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      cycles++;
    end
    check(cycles < 20000, "R2", "frame completes", cycles, w * h);
    if (mode == 0) check(cycles == w * h, "R7", "frame cycles", cycles, w * h);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    check(done == 1'b1, "R2", "done after last accept", int'(done), 1);
    check(n == nin, "R3", "inputs taken", n, nin);
    @(negedge clk);
    #1;
    check(done == 1'b0 && out_valid == 1'b0, "R2", "idle after done",
          int'({done, out_valid}), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_width = '0; cfg_height = '0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Idle with an eager source and sink: nothing may move (R1).
    in_valid = 1'b1; out_ready = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      check(!out_valid && !in_ready && !done, "R1", "idle outputs",
            int'({out_valid, in_ready, done}), 0);
    end
    run_frame(16, 16, 0, 1);
    run_frame(3,  3,  1, 2);
    run_frame(4,  5,  2, 3);
    run_frame(7,  3,  3, 4);
    run_frame(5,  8,  3, 5);
    run_frame(10, 12, 1, 6);
    run_frame(3,  16, 0, 7);
    run_frame(16, 4,  2, 8);
    run_frame(6,  6,  0, 9);
    run_frame(9,  7,  3, 10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule